// File: doc/BRIEF.md
# Fetch-Slotted DRAM Refresh Address Generator

This block produces the row address for dynamic memory refresh inside the bus interface of a small 8-bit processor. It holds an 8-bit row counter. Each time the processor finishes an opcode fetch, the block opens a one-cycle refresh window in the tail of that fetch. During the window it drives the row counter on the low byte of the address bus, forces the high byte to zero and raises a refresh strobe. When the window closes, the counter moves to the next row.

Because the window sits inside cycles that the fetch already uses, refresh costs the instruction stream no time. No interval timer is involved. Software can read the row counter at any time and can load it through a simple write port. A loaded value is the row used by the next refresh window.

Top module: `refresh_addr_gen`

## Requirements
- R1: While reset is asserted, and until the first refresh window after reset, the row counter reads 0x00, the refresh strobe is low and the refresh address is 0x0000.
- R2: A fetch-complete pulse sampled at a clock edge raises the refresh strobe for exactly the following cycle. The latency is always one cycle, and the strobe is never raised without such a pulse.
- R3: While the strobe is high, address bits 7:0 equal the current row counter and address bits 15:8 are zero.
- R4: The row counter increases by one at the clock edge that closes each refresh window. The new value is readable in the cycle after the window.
- R5: The row counter wraps from 0xFF to 0x00.
- R6: Without a refresh window or a write, the row counter holds its value.
- R7: A write loads the row counter at the next clock edge. The loaded value is the one driven in the next refresh window, including a window opened by a fetch pulse at the same edge.
- R8: When a write and a window close fall on the same edge, the written value is kept and the increment is lost.
- R9: Outside a refresh window the refresh address is 0x0000.
- R10: Fetch pulses on consecutive edges produce one window each. The strobe stays high for one cycle per pulse, showing consecutive rows, and the counter advances once per pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| fetch_done | input | 1 | One-cycle pulse marking the end of an opcode fetch |
| row_wr_en | input | 1 | Write strobe that loads the row counter |
| row_wr_data | input | 8 | Value loaded into the row counter |
| rfsh_addr | output | 16 | Refresh address; zero outside a refresh window |
| rfsh_strobe | output | 1 | Refresh control strobe |
| row_rd_data | output | 8 | Current row counter value |

## Verification
The hardest case to reach from the ports is a software load that lands on the same edge as a window close. The write must then beat the increment. The stimulus starts a fetch pulse and, in the cycle where the strobe is observed high, drives a write. It then checks that the read port shows the written value and not that value plus one, and that the next window drives it. A fetch pulse and a write on the same edge, wrap from 0xFF, and back-to-back fetch pulses that keep the strobe high for two cycles are each set up by a dedicated task from a known counter value.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int unsigned ROW_W  = 8;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/rfsh_rst_sync.sv
module rfsh_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
  parameter int unsigned ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [ROW_W-1:0] load_val,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_nxt;
  logic             row_en;

  // Next-state: a load overrides the step.
  always_comb begin
    row_en  = load | step;
    row_nxt = row_q;
    if (load)      row_nxt = load_val;
    else if (step) row_nxt = row_q + ROW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= row_nxt;
  end

  assign row = row_q;
endmodule

// File: rtl/rfsh_slot.sv
module rfsh_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_done,
  output logic slot_active,
  output logic slot_close
);
  logic slot_q;
  logic slot_nxt;

  always_comb slot_nxt = fetch_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= 1'b0;
    else        slot_q <= slot_nxt;
  end

  assign slot_active = slot_q;
  // Each open slot lasts one cycle and closes at the next edge.
  assign slot_close  = slot_q;
endmodule

// File: rtl/rfsh_addr_drive.sv
module rfsh_addr_drive #(
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              slot_active,
  input  logic [ROW_W-1:0]  row,
  output logic [ADDR_W-1:0] addr
);
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b < ROW_W) begin : g_row
      assign addr[b] = slot_active & row[b];
    end else begin : g_zero
      assign addr[b] = 1'b0;
    end
  end
endmodule

// File: rtl/refresh_addr_gen.sv
module refresh_addr_gen
  import rfsh_pkg::*;
#(
  parameter int unsigned RW = ROW_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_done,
  input  logic          row_wr_en,
  input  logic [RW-1:0] row_wr_data,
  output logic [AW-1:0] rfsh_addr,
  output logic          rfsh_strobe,
  output logic [RW-1:0] row_rd_data
);
  logic          rst_n_int;
  logic          slot_active;
  logic          slot_close;
  logic [RW-1:0] row;

  rfsh_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rfsh_slot u_slot (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .fetch_done  (fetch_done),
    .slot_active (slot_active),
    .slot_close  (slot_close)
  );

  rfsh_row_counter #(.ROW_W(RW)) u_row (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .step     (slot_close),
    .load     (row_wr_en),
    .load_val (row_wr_data),
    .row      (row)
  );

  rfsh_addr_drive #(.ROW_W(RW), .ADDR_W(AW)) u_addr (
    .slot_active (slot_active),
    .row         (row),
    .addr        (rfsh_addr)
  );

  assign rfsh_strobe = slot_active;
  assign row_rd_data = row;
endmodule

// File: rtl/refresh_addr_gen_chk.sv
module refresh_addr_gen_chk #(
  parameter int unsigned RW = 8,
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_done,
  input logic          row_wr_en,
  input logic [RW-1:0] row_wr_data,
  input logic [AW-1:0] rfsh_addr,
  input logic          rfsh_strobe,
  input logic [RW-1:0] row_rd_data
);
  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> rfsh_strobe);

  assert_no_spurious_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_done |=> !rfsh_strobe);

  assert_addr_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_strobe |-> (rfsh_addr == AW'(row_rd_data)));

  assert_step_after_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_strobe && !row_wr_en) |=> (row_rd_data == RW'($past(row_rd_data) + RW'(1))));

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rfsh_strobe && !row_wr_en) |=> $stable(row_rd_data));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    row_wr_en |=> (row_rd_data == $past(row_wr_data)));

  assert_addr_zero_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_strobe |-> (rfsh_addr == '0));
endmodule

bind refresh_addr_gen refresh_addr_gen_chk #(.RW(RW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_int),
  .fetch_done  (fetch_done),
  .row_wr_en   (row_wr_en),
  .row_wr_data (row_wr_data),
  .rfsh_addr   (rfsh_addr),
  .rfsh_strobe (rfsh_strobe),
  .row_rd_data (row_rd_data)
);

// File: tb/test_refresh_addr_gen.sv
`timescale 1ns/100ps
module test_refresh_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_done;
  logic        row_wr_en;
  logic [7:0]  row_wr_data;
  logic [15:0] rfsh_addr;
  logic        rfsh_strobe;
  logic [7:0]  row_rd_data;

  int n_vec  = 0;
  int n_miss = 0;
  logic [7:0] exp_row;

  always #2.5 clk = ~clk;

  refresh_addr_gen i_refresh_addr_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_done  (fetch_done),
    .row_wr_en   (row_wr_en),
    .row_wr_data (row_wr_data),
    .rfsh_addr   (rfsh_addr),
    .rfsh_strobe (rfsh_strobe),
    .row_rd_data (row_rd_data)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nedge;
    @(negedge clk);
  endtask

  // One fetch pulse; checks the window and the row step (R2, R3, R4, R9)
  task automatic t_single_fetch;
    fetch_done = 1'b1;
    nedge();
    fetch_done = 1'b0;
    chk("R2 strobe high", 16'(rfsh_strobe), 16'd1);
    chk("R3 address in window", rfsh_addr, {8'h00, exp_row});
    nedge();
    exp_row = exp_row + 8'd1;
    chk("R2 strobe one cycle", 16'(rfsh_strobe), 16'd0);
    chk("R9 address idle", rfsh_addr, 16'h0000);
    chk("R4 row stepped", 16'(row_rd_data), 16'(exp_row));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; fetch_done = 1'b0; row_wr_en = 1'b0; row_wr_data = '0;
    #7;
    nedge();
    chk("R1 row reset", 16'(row_rd_data), 16'h0000);
    chk("R1 strobe reset", 16'(rfsh_strobe), 16'd0);
    chk("R1 address reset", rfsh_addr, 16'h0000);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) nedge();
    exp_row = 8'h00;
    chk("R1 row after release", 16'(row_rd_data), 16'h0000);
  endtask

  task automatic t_write(input logic [7:0] v);
    row_wr_en = 1'b1; row_wr_data = v;
    nedge();
    row_wr_en = 1'b0;
    exp_row = v;
    chk("R7 load visible", 16'(row_rd_data), 16'(v));
  endtask

  task automatic t_idle;
    for (int i = 0; i < 10; i++) begin
      nedge();
      chk("R6 row holds", 16'(row_rd_data), 16'(exp_row));
      chk("R2 no strobe without fetch", 16'(rfsh_strobe), 16'd0);
      chk("R9 idle address zero", rfsh_addr, 16'h0000);
    end
  endtask

  task automatic t_wrap;
    t_write(8'hFF);
    t_single_fetch();
    chk("R5 wrap to zero", 16'(row_rd_data), 16'h0000);
  endtask

  task automatic t_write_then_slot;
    t_write(8'h5A);
    t_single_fetch();
    chk("R7 loaded row used then stepped", 16'(row_rd_data), 16'h005B);
  endtask

  task automatic t_write_with_fetch;
    fetch_done = 1'b1; row_wr_en = 1'b1; row_wr_data = 8'h33;
    nedge();
    fetch_done = 1'b0; row_wr_en = 1'b0;
    chk("R7 same-edge load drives window", rfsh_addr, 16'h0033);
    nedge();
    chk("R7 same-edge load then step", 16'(row_rd_data), 16'h0034);
    exp_row = 8'h34;
  endtask

  task automatic t_collide;
    fetch_done = 1'b1;
    nedge();
    fetch_done = 1'b0;
    chk("R2 strobe before collide", 16'(rfsh_strobe), 16'd1);
    row_wr_en = 1'b1; row_wr_data = 8'h40;
    nedge();
    row_wr_en = 1'b0;
    chk("R8 write wins over step", 16'(row_rd_data), 16'h0040);
    exp_row = 8'h40;
    t_single_fetch();
  endtask

  task automatic t_back_to_back;
    logic [7:0] base;
    base = exp_row;
    fetch_done = 1'b1;
    nedge();
    chk("R10 first window row", rfsh_addr, {8'h00, base});
    nedge();
    fetch_done = 1'b0;
    chk("R10 strobe stays high", 16'(rfsh_strobe), 16'd1);
    chk("R10 second window row", rfsh_addr, {8'h00, base + 8'd1});
    nedge();
    exp_row = base + 8'd2;
    chk("R10 strobe drops", 16'(rfsh_strobe), 16'd0);
    chk("R10 two steps", 16'(row_rd_data), 16'(exp_row));
  endtask

  task automatic t_reset_midrun;
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears row", 16'(row_rd_data), 16'h0000);
    nedge();
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) nedge();
    exp_row = 8'h00;
    t_single_fetch();
  endtask

  initial begin
    t_reset();
    t_single_fetch();
    t_single_fetch();
    t_idle();
    t_wrap();
    t_write_then_slot();
    t_write_with_fetch();
    t_collide();
    t_back_to_back();
    t_write(8'hFE);
    t_back_to_back();
    chk("R5 wrap on back-to-back", 16'(row_rd_data), 16'h0000);
    t_reset_midrun();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule